// File: doc/BRIEF.md
# Three-Phase Edge-Aligned PWM Generator

This block drives three half-bridge phase pairs from one shared 16-bit up-counter. Software loads a period value and three duty values through a small synchronous write port. The counter climbs from zero to the period value and then restarts. Every restart begins a new PWM cycle with each phase active. A phase goes inactive when the counter reaches that phase's duty value. Each phase has a positive pin and a complementary negative pin. Each pin group has its own active-level select.

Duty writes land in shadow registers. They move into the working compare registers only at a counter restart, so a cycle in progress never sees a torn duty. An external cut-off input drives all six pins to their inactive levels, whatever the counter is doing. The input is brought in through a two-stage synchronizer and held in a sticky latch. Software releases the latch with a clear bit, and the clear works only after the input has gone low.

Top module: `pwm3_reset_sync`

## Requirements
- R1: While the run bit (control register, address 0, bit 0) is 1, the counter increments once per clock and goes to 0 on the clock after it equals the period (address 1), giving period+1 states per PWM cycle; while the run bit is 0 the counter is held at the period value, so the first running clock is a restart.
- R2: Each phase's internal level is active for the counter values 0 to duty-1 of every cycle and inactive for the rest. The level is set at each restart and toggles once when the counter reaches the duty value. Duty registers are at address 2 (U, output bit 0), 3 (V, bit 1) and 4 (W, bit 2). Pins are registered and lag that level by one clock.
- R3: A duty of 0 keeps the phase inactive for the whole cycle, and a duty greater than the period keeps it active for the whole cycle, with no pulse at the restart.
- R4: Each negative pin carries the complement of its phase level. Control bit 1 set to 1 makes the positive pins active-high, and 0 makes them active-low. Control bit 2 does the same for the negative pins. Both bits reset to 1.
- R5: A duty write changes nothing in the cycle that is running. The new value takes effect from the next restart.
- R6: When the cut-off input is high, all positive pins go to the inverse of control bit 1 and all negative pins go to the inverse of control bit 2. This happens on the third rising clock edge after the input is sampled high, and the pins stay there after the input falls.
- R7: Writing 1 to control bit 3 (a self-clearing bit) releases the cut-off state only if the synchronized cut-off input is low. While the input is high, the write has no effect.
- R8: Writes to addresses 5 to 7 change no state.
- R9: After reset the counter is stopped and both polarity bits are 1. Once one clock has passed, the positive pins are 0 and the negative pins are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| cutoff_in | input | 1 | External cut-off request, asynchronous |
| pos_out | output | 3 | Positive phase pins, bit 0 = U, bit 1 = V, bit 2 = W |
| neg_out | output | 3 | Negative phase pins, same bit order |

## Verification
The hardest case is a duty write that lands in the middle of a running cycle. The bench waits until its own model shows the counter just past the old duty value, then writes a larger duty. It checks that the phase stays inactive for the rest of that cycle, and that the full next cycle shows the new width. The second hard case is the cut-off release. A clear issued while the input is still high must fail. The bench repeats the clear after the input falls, and the outputs must come back in step with the counter.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  localparam int unsigned DW  = 16;
  localparam int unsigned AW  = 3;
  localparam int unsigned NPH = 3;

  localparam logic [AW-1:0] ADDR_CTRL   = 3'd0;
  localparam logic [AW-1:0] ADDR_PERIOD = 3'd1;
  localparam logic [AW-1:0] ADDR_DUTY0  = 3'd2;

  localparam int unsigned CB_RUN   = 0;
  localparam int unsigned CB_POLP  = 1;
  localparam int unsigned CB_POLN  = 2;
  localparam int unsigned CB_CUTCL = 3;
endpackage

// File: rtl/pwm3_regs.sv
module pwm3_regs
  import pwm3_pkg::*;
#(
  parameter int unsigned P_DW  = DW,
  parameter int unsigned P_AW  = AW,
  parameter int unsigned P_NPH = NPH
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [P_AW-1:0]            wr_addr,
  input  logic [P_DW-1:0]            wr_data,
  output logic                       run,
  output logic                       pol_p,
  output logic                       pol_n,
  output logic                       cut_clr,
  output logic [P_DW-1:0]            period,
  output logic [P_NPH-1:0][P_DW-1:0] duty_buf
);
  logic                       run_d, pol_p_d, pol_n_d;
  logic [P_DW-1:0]            period_d;
  logic [P_NPH-1:0][P_DW-1:0] duty_d;
  logic                       sel_ctrl, sel_period;

  assign sel_ctrl   = wr_en && (wr_addr == ADDR_CTRL);
  assign sel_period = wr_en && (wr_addr == ADDR_PERIOD);
  assign cut_clr    = sel_ctrl && wr_data[CB_CUTCL];

  always_comb begin
    run_d    = run;
    pol_p_d  = pol_p;
    pol_n_d  = pol_n;
    period_d = period;
    if (sel_ctrl) begin
      run_d   = wr_data[CB_RUN];
      pol_p_d = wr_data[CB_POLP];
      pol_n_d = wr_data[CB_POLN];
    end
    if (sel_period) period_d = wr_data;
  end

  for (genvar g = 0; g < P_NPH; g++) begin : g_duty
    always_comb begin
      duty_d[g] = duty_buf[g];
      if (wr_en && (wr_addr == P_AW'(ADDR_DUTY0 + g))) duty_d[g] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      pol_p    <= 1'b1;
      pol_n    <= 1'b1;
      period   <= '0;
      duty_buf <= '0;
    end else begin
      run      <= run_d;
      pol_p    <= pol_p_d;
      pol_n    <= pol_n_d;
      period   <= period_d;
      duty_buf <= duty_d;
    end
  end
endmodule

// File: rtl/pwm3_counter.sv
module pwm3_counter #(
  parameter int unsigned P_DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [P_DW-1:0] period,
  output logic [P_DW-1:0] cnt,
  output logic            clr_evt
);
  logic [P_DW-1:0] cnt_d;

  assign clr_evt = run && (cnt == period);

  always_comb begin
    if (!run)        cnt_d = period;
    else if (clr_evt) cnt_d = '0;
    else              cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/pwm3_phase.sv
module pwm3_phase #(
  parameter int unsigned P_DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            clr_evt,
  input  logic [P_DW-1:0] cnt,
  input  logic [P_DW-1:0] duty_buf,
  output logic [P_DW-1:0] cmp_act,
  output logic            lvl
);
  localparam int unsigned XW = P_DW + 1;
  logic [P_DW-1:0] cmp_d;
  logic            lvl_d;
  logic [XW-1:0]   cnt_nx;
  logic            hit;

  assign cnt_nx = {1'b0, cnt} + XW'(1);
  assign hit    = (cnt_nx == {1'b0, cmp_act});

  always_comb begin
    cmp_d = cmp_act;
    lvl_d = lvl;
    if (!run) begin
      lvl_d = 1'b0;
    end else if (clr_evt) begin
      cmp_d = duty_buf;
      lvl_d = |duty_buf;
    end else if (hit) begin
      lvl_d = ~lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_act <= '0;
      lvl     <= 1'b0;
    end else begin
      cmp_act <= cmp_d;
      lvl     <= lvl_d;
    end
  end
endmodule

// File: rtl/pwm3_cutoff.sv
module pwm3_cutoff (
  input  logic clk,
  input  logic rst_n,
  input  logic cutoff_in,
  input  logic cut_clr,
  output logic cut_lat,
  output logic cut_force
);
  logic sync1, sync2, lat_d;

  always_comb begin
    lat_d = cut_lat;
    if (sync2)        lat_d = 1'b1;
    else if (cut_clr) lat_d = 1'b0;
  end

  assign cut_force = sync2 | cut_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1   <= 1'b0;
      sync2   <= 1'b0;
      cut_lat <= 1'b0;
    end else begin
      sync1   <= cutoff_in;
      sync2   <= sync1;
      cut_lat <= lat_d;
    end
  end
endmodule

// File: rtl/pwm3_reset_sync.sv
module pwm3_reset_sync
  import pwm3_pkg::*;
#(
  parameter int unsigned P_DW  = DW,
  parameter int unsigned P_AW  = AW,
  parameter int unsigned P_NPH = NPH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [P_AW-1:0]  wr_addr,
  input  logic [P_DW-1:0]  wr_data,
  input  logic             cutoff_in,
  output logic [P_NPH-1:0] pos_out,
  output logic [P_NPH-1:0] neg_out
);
  logic                       run, pol_p, pol_n, cut_clr;
  logic [P_DW-1:0]            period, cnt_q;
  logic [P_NPH-1:0][P_DW-1:0] duty_buf, cmp_act;
  logic                       clr_evt, cut_lat, cut_force;
  logic [P_NPH-1:0]           lvl, pos_d, neg_d;

  pwm3_regs #(.P_DW(P_DW), .P_AW(P_AW), .P_NPH(P_NPH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .run(run), .pol_p(pol_p), .pol_n(pol_n), .cut_clr(cut_clr),
    .period(period), .duty_buf(duty_buf)
  );

  pwm3_counter #(.P_DW(P_DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .period(period),
    .cnt(cnt_q), .clr_evt(clr_evt)
  );

  for (genvar g = 0; g < P_NPH; g++) begin : g_ph
    pwm3_phase #(.P_DW(P_DW)) u_ph (
      .clk(clk), .rst_n(rst_n), .run(run), .clr_evt(clr_evt), .cnt(cnt_q),
      .duty_buf(duty_buf[g]), .cmp_act(cmp_act[g]), .lvl(lvl[g])
    );
  end

  pwm3_cutoff u_cut (
    .clk(clk), .rst_n(rst_n), .cutoff_in(cutoff_in), .cut_clr(cut_clr),
    .cut_lat(cut_lat), .cut_force(cut_force)
  );

  always_comb begin
    if (cut_force) begin
      pos_d = {P_NPH{~pol_p}};
      neg_d = {P_NPH{~pol_n}};
    end else begin
      pos_d = ~(lvl ^ {P_NPH{pol_p}});
      neg_d = lvl ^ {P_NPH{pol_n}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_out <= '0;
      neg_out <= '0;
    end else begin
      pos_out <= pos_d;
      neg_out <= neg_d;
    end
  end
endmodule

// File: rtl/pwm3_chk.sv
module pwm3_chk #(
  parameter int unsigned P_DW  = 16,
  parameter int unsigned P_NPH = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       run,
  input logic                       clr_evt,
  input logic [P_DW-1:0]            cnt,
  input logic [P_DW-1:0]            period,
  input logic                       pol_p,
  input logic                       pol_n,
  input logic                       cut_force,
  input logic                       cut_lat,
  input logic                       cut_clr,
  input logic [P_NPH-1:0][P_DW-1:0] cmp_act,
  input logic [P_NPH-1:0]           pos_out,
  input logic [P_NPH-1:0]           neg_out
);
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == period) |=> (cnt == '0)); // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt != period) |=> (cnt == $past(cnt) + 1'b1)); // R1
  AST_CNT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |=> (cnt == $past(period))); // R1
  AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_evt) |=> $stable(cmp_act)); // R5
  AST_PAIR_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
    (!cut_force) |=> ((pos_out ^ neg_out) == {P_NPH{~($past(pol_p) ^ $past(pol_n))}})); // R4
  AST_CUT_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    cut_force |=> (pos_out == {P_NPH{~$past(pol_p)}} && neg_out == {P_NPH{~$past(pol_n)}})); // R6
  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cut_lat && !cut_clr) |=> cut_lat); // R7
endmodule

bind pwm3_reset_sync pwm3_chk #(.P_DW(P_DW), .P_NPH(P_NPH)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .clr_evt(clr_evt), .cnt(cnt_q),
  .period(period), .pol_p(pol_p), .pol_n(pol_n), .cut_force(cut_force),
  .cut_lat(cut_lat), .cut_clr(cut_clr), .cmp_act(cmp_act),
  .pos_out(pos_out), .neg_out(neg_out)
);

// File: tb/pwm3_reset_sync_tb_top.sv
module pwm3_reset_sync_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        cutoff_in = 1'b0;
  logic [2:0]  pos_out, neg_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  pwm3_reset_sync dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cutoff_in(cutoff_in), .pos_out(pos_out), .neg_out(neg_out)
  );

  // reference model built from the requirements
  logic        m_run, m_pp, m_pn, m_s1, m_s2, m_lat;
  logic [15:0] m_per, m_cnt;
  logic [15:0] m_buf [3];
  logic [15:0] m_act [3];
  logic [2:0]  m_lvl, m_pos, m_neg;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run <= 0; m_pp <= 1; m_pn <= 1; m_s1 <= 0; m_s2 <= 0; m_lat <= 0;
      m_per <= 0; m_cnt <= 0; m_lvl <= 0; m_pos <= 0; m_neg <= 0;
      for (int i = 0; i < 3; i++) begin m_buf[i] <= 0; m_act[i] <= 0; end
    end else begin
      m_s1 <= cutoff_in;
      m_s2 <= m_s1;
      if (m_s2) m_lat <= 1;
      else if (wr_en && wr_addr == 0 && wr_data[3]) m_lat <= 0;
      if (wr_en && wr_addr == 0) begin
        m_run <= wr_data[0]; m_pp <= wr_data[1]; m_pn <= wr_data[2];
      end
      if (wr_en && wr_addr == 1) m_per <= wr_data;
      for (int i = 0; i < 3; i++)
        if (wr_en && wr_addr == 3'(2 + i)) m_buf[i] <= wr_data;
      if (!m_run) begin
        m_cnt <= m_per;
        m_lvl <= 0;
      end else if (m_cnt == m_per) begin
        m_cnt <= 0;
        for (int i = 0; i < 3; i++) begin
          m_act[i] <= m_buf[i];
          m_lvl[i] <= (m_buf[i] != 0);
        end
      end else begin
        m_cnt <= m_cnt + 1;
        for (int i = 0; i < 3; i++)
          if ({1'b0, m_cnt} + 17'd1 == {1'b0, m_act[i]}) m_lvl[i] <= 0;
      end
      for (int i = 0; i < 3; i++) begin
        if (m_s2 || m_lat) begin
          m_pos[i] <= ~m_pp; m_neg[i] <= ~m_pn;
        end else begin
          m_pos[i] <= m_pp ? m_lvl[i] : ~m_lvl[i];
          m_neg[i] <= m_pn ? ~m_lvl[i] : m_lvl[i];
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock, then compare pins against the model away from the edge
  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check("R2 pos vs model", {29'd0, pos_out}, {29'd0, m_pos});
      check("R4 neg vs model", {29'd0, neg_out}, {29'd0, m_neg});
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 0;
  endtask

  task automatic high_count(input int ph, input int len, input bit neg, output int cnt);
    cnt = 0;
    for (int k = 0; k < len; k++) begin
      step(1);
      cnt += neg ? int'(neg_out[ph]) : int'(pos_out[ph]);
    end
  endtask

  task automatic t_reset();
    step(2);
    check("R9 pos after reset", {29'd0, pos_out}, 32'd0);
    check("R9 neg after reset", {29'd0, neg_out}, 32'd7);
  endtask

  task automatic t_duty();
    int h;
    wr(1, 16'd9);
    wr(2, 16'd3); wr(3, 16'd5); wr(4, 16'd7);
    wr(0, 16'h0007);
    step(25);
    high_count(0, 10, 0, h); check("R2 U width", h, 3);
    high_count(1, 10, 0, h); check("R2 V width", h, 5);
    high_count(2, 10, 0, h); check("R2 W width", h, 7);
    high_count(1, 10, 1, h); check("R4 V neg width", h, 5);
  endtask

  task automatic t_extremes();
    int h;
    wr(2, 16'd0); wr(3, 16'd10); wr(4, 16'd9);
    step(22);
    high_count(0, 20, 0, h); check("R3 duty 0 never active", h, 0);
    high_count(1, 20, 0, h); check("R3 duty over period always active", h, 20);
    high_count(2, 10, 0, h); check("R2 duty equal period", h, 9);
  endtask

  task automatic t_polarity();
    int h;
    wr(2, 16'd3);
    wr(0, 16'h0001);
    step(22);
    high_count(0, 10, 0, h); check("R4 pos active-low", h, 7);
    high_count(0, 10, 1, h); check("R4 neg active-low", h, 3);
    wr(0, 16'h0007);
    step(12);
  endtask

  task automatic t_buffer();
    int h;
    while (m_cnt != 16'd4) step(1);
    wr(2, 16'd8);
    h = 0;
    while (m_cnt != 16'd9) begin step(1); h += int'(pos_out[0]); end
    check("R5 old duty holds in running cycle", h, 0);
    step(12);
    high_count(0, 10, 0, h); check("R5 new duty after restart", h, 8);
    wr(2, 16'd3);
    step(22);
  endtask

  task automatic t_unmapped();
    int h;
    wr(5, 16'hFFFF); wr(6, 16'h0000); wr(7, 16'h1234);
    step(22);
    high_count(0, 10, 0, h); check("R8 U unchanged", h, 3);
    high_count(2, 10, 0, h); check("R8 W unchanged", h, 9);
  endtask

  task automatic t_cutoff();
    int h;
    @(negedge clk); cutoff_in = 1;
    step(2);
    step(1);
    check("R6 pos forced", {29'd0, pos_out}, 32'd0);
    check("R6 neg forced", {29'd0, neg_out}, 32'd0);
    wr(0, 16'h000F);
    step(3);
    check("R7 clear ignored while high", {29'd0, neg_out}, 32'd0);
    cutoff_in = 0;
    high_count(1, 20, 0, h); check("R6 latch holds after input falls", h, 0);
    wr(0, 16'h000F);
    step(22);
    high_count(0, 10, 0, h); check("R7 outputs resume after clear", h, 3);
  endtask

  task automatic t_stop();
    wr(0, 16'h0006);
    step(3);
    check("R1 stopped pos inactive", {29'd0, pos_out}, 32'd0);
    check("R1 stopped neg", {29'd0, neg_out}, 32'd7);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_duty();
    t_extremes();
    t_polarity();
    t_buffer();
    t_unmapped();
    t_cutoff();
    t_stop();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule